// File: doc/BRIEF.md
# Multi-Mode Counter Input Decoder

This block sits in front of one counter channel and converts two raw input levels, A and B, into single-clock count-up and count-down strobes. A 3-bit select chooses how the two inputs are read: as a pulse with a direction level, as a pulse with a direction bit from inside the chip, as separate up and down pulse lines, or as a quadrature encoder pair decoded at one, two or four counts per encoder cycle.

Both inputs first pass through a synchroniser. Edges are then found by comparing each synchronised level with its value one clock earlier. A combinational decoder maps the edges to up and down requests, and an output register turns those requests into strobes. When an up request and a down request arrive in the same clock, they cancel each other. A change of the select discards the edge that is in flight, so the switch between modes cannot create a false count. The counter register that consumes the strobes lies outside this block.

Top module: `cnt_in_decoder`

## Requirements
- R1: While reset is low, both strobes are low. After reset, both input levels are taken as low, and no strobe fires until an input edge arrives.
- R2: With the default two synchroniser stages, an input edge that is set up before a clock edge produces its strobe after the third rising clock edge. The strobe lasts exactly one clock.
- R3: With select 0 (pulse, external direction), a rising edge of A gives an up strobe when B is low and a down strobe when B is high. A falling edge of A, and any edge of B, gives no strobe.
- R4: With select 2 (up/down pulses), a rising edge of A gives an up strobe and a rising edge of B gives a down strobe. Falling edges give no strobe.
- R5: With select 1 (pulse, internal direction), a rising edge of A gives an up strobe when dir_int is 0 and a down strobe when dir_int is 1. Edges of B give no strobe.
- R6: With select 3 (quadrature x1), a rising edge of A while B is low gives an up strobe. A falling edge of A while B is low gives a down strobe. Every other edge is ignored, so one encoder cycle gives one count.
- R7: With select 4 (quadrature x2), every edge of A counts, and each encoder cycle gives two counts. Up is a rising A with B low, or a falling A with B high. The other two cases count down.
- R8: With select 5 (quadrature x4), every edge of A and of B counts, and each encoder cycle gives four counts. The direction is up when A leads B (sequence AB = 10, 11, 01, 00) and down when B leads A.
- R9: If one clock yields both an up request and a down request, neither strobe fires. Examples are A and B rising together in select 2 or in select 5.
- R10: An edge that reaches the decoder in the same clock as a change of the select is discarded, and no strobe results from it.
- R11: Select values 6 and 7 are reserved. With either of them, no strobe fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 1 | Raw A input level (asynchronous) |
| b_in | input | 1 | Raw B input level (asynchronous) |
| dir_int | input | 1 | Direction bit for select 1: 0 counts up, 1 counts down |
| cfg_sel | input | 3 | Input configuration select, 0 to 5; 6 and 7 are reserved |
| up_stb | output | 1 | One-clock count-up strobe |
| dn_stb | output | 1 | One-clock count-down strobe |

## Verification
Each pulse mode is driven with A pulses under both direction settings and with B pulses alone, which separates the level-steered modes from the edge-steered mode. The three quadrature modes each receive the same forward and reverse encoder sequences, and the up and down totals must come out at 1, 2 or 4 per cycle; this tells the resolutions apart and exposes any edge that is counted in the wrong direction. Simultaneous A and B edges test the cancel rule. A select change timed to coincide with an edge arriving at the decoder, with a normal edge afterwards as the control case, checks that the in-flight edge is discarded. A single-edge timing probe fixes the three-clock latency and the one-clock strobe width.

// File: rtl/cnt_in_pkg.sv
// Package: shared types for the counter input decoder.
// Assumes a 3-bit configuration select; values above CFG_QUAD_X4 are reserved.
package cnt_in_pkg;
    localparam int CFG_W = 3;

    typedef enum logic [CFG_W-1:0] {
        CFG_PULSE_EXT = 3'd0,
        CFG_PULSE_INT = 3'd1,
        CFG_UP_DOWN   = 3'd2,
        CFG_QUAD_X1   = 3'd3,
        CFG_QUAD_X2   = 3'd4,
        CFG_QUAD_X4   = 3'd5,
        CFG_RSVD6     = 3'd6,
        CFG_RSVD7     = 3'd7
    } in_cfg_e;

    // Per-input edge flags after detection.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;
endpackage

// File: rtl/cin_sync.sv
// Module: multi-stage synchroniser for asynchronous input levels.
// Assumes STAGES >= 2; every stage resets to 0, so inputs are taken as low after reset.
module cin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Later stages: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cin_edge.sv
// Module: edge detector on synchronised levels.
// It keeps the previous level of each input. The clr input masks the edge flags
// of the current clock; the previous-level register reloads every clock.
module cin_edge
    import cnt_in_pkg::*;
#(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] lvl,
    output edge_t            edges [WIDTH]
);
    logic [WIDTH-1:0] prev_q;

    // Previous-level register, loaded with the current level every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // Edge flags of one input, masked while clr is high.
            always_comb begin
                edges[i].rise = !clr &&  lvl[i] && !prev_q[i];
                edges[i].fall = !clr && !lvl[i] &&  prev_q[i];
            end
        end
    endgenerate
endmodule

// File: rtl/cin_decode.sv
// Module: combinational mapping from edges and levels to up/down requests.
// It assumes the edges and the levels come from the same synchronised sample.
// Reserved selects yield no request.
module cin_decode
    import cnt_in_pkg::*;
(
    input  in_cfg_e cfg,
    input  logic    a_lvl,
    input  logic    b_lvl,
    input  edge_t   a_e,
    input  edge_t   b_e,
    input  logic    dir_int,
    output logic    up_req,
    output logic    dn_req
);
    // Select the counting rule for the active configuration.
    always_comb begin
        up_req = 1'b0;
        dn_req = 1'b0;
        case (cfg)
            CFG_PULSE_EXT: begin
                up_req = a_e.rise && !b_lvl;
                dn_req = a_e.rise &&  b_lvl;
            end
            CFG_PULSE_INT: begin
                up_req = a_e.rise && !dir_int;
                dn_req = a_e.rise &&  dir_int;
            end
            CFG_UP_DOWN: begin
                up_req = a_e.rise;
                dn_req = b_e.rise;
            end
            CFG_QUAD_X1: begin
                up_req = a_e.rise && !b_lvl;
                dn_req = a_e.fall && !b_lvl;
            end
            CFG_QUAD_X2: begin
                up_req = (a_e.rise && !b_lvl) || (a_e.fall &&  b_lvl);
                dn_req = (a_e.rise &&  b_lvl) || (a_e.fall && !b_lvl);
            end
            CFG_QUAD_X4: begin
                up_req = (a_e.rise && !b_lvl) || (a_e.fall &&  b_lvl) ||
                         (b_e.rise &&  a_lvl) || (b_e.fall && !a_lvl);
                dn_req = (a_e.rise &&  b_lvl) || (a_e.fall && !b_lvl) ||
                         (b_e.rise && !a_lvl) || (b_e.fall &&  a_lvl);
            end
            default: begin
                up_req = 1'b0;
                dn_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cnt_in_decoder.sv
// Module: top of the counter input decoder.
// Raw A/B levels pass through the synchroniser, the edge detector and the mode
// decoder, and the output register issues one-clock strobes. Opposite requests
// in one clock cancel. A change of the select masks the edge in flight.
module cnt_in_decoder
    import cnt_in_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_in,
    input  logic             b_in,
    input  logic             dir_int,
    input  logic [CFG_W-1:0] cfg_sel,
    output logic             up_stb,
    output logic             dn_stb
);
    localparam int N_IN  = 2;
    localparam int IDX_A = 0;
    localparam int IDX_B = 1;

    logic [N_IN-1:0]  raw_lvl;
    logic [N_IN-1:0]  sync_lvl;
    edge_t            edges [N_IN];
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;
    logic             up_req;
    logic             dn_req;
    logic             a_rise;
    logic             a_fall;
    logic             b_rise;

    assign raw_lvl = {b_in, a_in};

    cin_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_lvl),
        .q_sync  (sync_lvl)
    );

    // Previous select; during reset it follows the input so no change is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_sel;
        else        cfg_q <= cfg_sel;
    end

    assign cfg_chg = (cfg_sel != cfg_q);

    cin_edge #(.WIDTH(N_IN)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_chg),
        .lvl   (sync_lvl),
        .edges (edges)
    );

    assign a_rise = edges[IDX_A].rise;
    assign a_fall = edges[IDX_A].fall;
    assign b_rise = edges[IDX_B].rise;

    cin_decode u_dec (
        .cfg     (in_cfg_e'(cfg_sel)),
        .a_lvl   (sync_lvl[IDX_A]),
        .b_lvl   (sync_lvl[IDX_B]),
        .a_e     (edges[IDX_A]),
        .b_e     (edges[IDX_B]),
        .dir_int (dir_int),
        .up_req  (up_req),
        .dn_req  (dn_req)
    );

    // Output strobes; opposite requests in the same clock cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_stb <= 1'b0;
            dn_stb <= 1'b0;
        end else begin
            up_stb <= up_req && !dn_req;
            dn_stb <= dn_req && !up_req;
        end
    end
endmodule

// File: rtl/cnt_in_decoder_chk.sv
// Module: assertion checker for cnt_in_decoder, attached through bind.
// It observes the ports and the edge flags that the edge detector drives.
module cnt_in_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cfg_sel,
    input logic       a_rise,
    input logic       a_fall,
    input logic       b_rise,
    input logic       up_stb,
    input logic       dn_stb
);
    // R1: after a reset clock, both strobes are low.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!up_stb && !dn_stb));

    // R9: the two strobes never fire together.
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_stb && dn_stb));

    // R10: a select change suppresses the strobes one clock later.
    assert_cfg_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel != $past(cfg_sel)) |=> (!up_stb && !dn_stb));

    // R11: a reserved select produces no strobe.
    assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel >= 3'd6) |=> (!up_stb && !dn_stb));

    // R6: in x1 mode, every strobe comes from an edge of A.
    assert_x1_a_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((up_stb || dn_stb) && $past(cfg_sel) == 3'd3) |-> $past(a_rise || a_fall));

    // R4: in up/down mode, a down strobe comes from a rising edge of B.
    assert_updown_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_stb && $past(cfg_sel) == 3'd2) |-> $past(b_rise));
endmodule

bind cnt_in_decoder cnt_in_decoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_sel (cfg_sel),
    .a_rise  (a_rise),
    .a_fall  (a_fall),
    .b_rise  (b_rise),
    .up_stb  (up_stb),
    .dn_stb  (dn_stb)
);

// File: tb/cnt_in_decoder_tb.sv
`timescale 1ns/1ps
module cnt_in_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a_in = 1'b0;
    logic       b_in = 1'b0;
    logic       dir_int = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       up_stb;
    logic       dn_stb;

    int n_checks = 0;
    int n_errors = 0;
    int n_up = 0;
    int n_dn = 0;

    always #2 clk = ~clk;

    cnt_in_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .dir_int(dir_int), .cfg_sel(cfg_sel), .up_stb(up_stb), .dn_stb(dn_stb)
    );

    // Strobe counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (up_stb) n_up++;
        if (dn_stb) n_dn++;
    end

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input logic a, input logic b);
        @(negedge clk);
        a_in = a;
        b_in = b;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [2:0] v);
        @(negedge clk);
        cfg_sel = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic clr_cnt();
        n_up = 0;
        n_dn = 0;
    endtask

    task automatic quad_fwd(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            apply(1, 0); apply(1, 1); apply(0, 1); apply(0, 0);
        end
    endtask

    task automatic quad_rev(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            apply(0, 1); apply(1, 1); apply(1, 0); apply(0, 0);
        end
    endtask

    task automatic t_reset();
        int seen = 0;
        rst_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (up_stb || dn_stb) seen++;
        end
        @(negedge clk) rst_n = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (up_stb || dn_stb) seen++;
        end
        chk("R1 strobes idle in and after reset", seen, 0);
        clr_cnt();
    endtask

    task automatic t_latency();
        int s1, s2, s3, s4;
        set_cfg(3'd2);
        @(negedge clk) a_in = 1'b1;
        @(negedge clk) s1 = up_stb;
        @(negedge clk) s2 = up_stb;
        @(negedge clk) s3 = up_stb;
        @(negedge clk) s4 = up_stb;
        chk("R2 no strobe after 1st edge", s1, 0);
        chk("R2 no strobe after 2nd edge", s2, 0);
        chk("R2 strobe after 3rd edge", s3, 1);
        chk("R2 strobe one clock wide", s4, 0);
        apply(0, 0);
        clr_cnt();
    endtask

    task automatic t_ext_dir();
        set_cfg(3'd0); clr_cnt();
        for (int i = 0; i < 3; i++) begin apply(1, 0); apply(0, 0); end
        chk("R3 up with B low", n_up, 3);
        chk("R3 no down with B low", n_dn, 0);
        apply(0, 1); clr_cnt();
        for (int i = 0; i < 2; i++) begin apply(1, 1); apply(0, 1); end
        chk("R3 down with B high", n_dn, 2);
        chk("R3 no up with B high", n_up, 0);
        apply(0, 0);
        chk("R3 B edges ignored", n_up + n_dn, 2);
        clr_cnt();
    endtask

    task automatic t_int_dir();
        set_cfg(3'd1); clr_cnt();
        dir_int = 1'b0;
        apply(1, 0); apply(0, 0); apply(1, 0); apply(0, 0);
        chk("R5 up with dir 0", n_up, 2);
        dir_int = 1'b1; clr_cnt();
        apply(1, 0); apply(0, 0);
        chk("R5 down with dir 1", n_dn, 1);
        clr_cnt();
        apply(0, 1); apply(0, 0); apply(0, 1); apply(0, 0);
        chk("R5 B ignored", n_up + n_dn, 0);
        dir_int = 1'b0;
    endtask

    task automatic t_up_down();
        set_cfg(3'd2); clr_cnt();
        apply(1, 0); apply(0, 0); apply(1, 0); apply(0, 0);
        apply(0, 1); apply(0, 0);
        chk("R4 A pulses count up", n_up, 2);
        chk("R4 B pulse counts down", n_dn, 1);
        clr_cnt();
        apply(1, 1); apply(0, 0);
        chk("R9 simultaneous A and B cancel", n_up + n_dn, 0);
    endtask

    task automatic t_x1();
        set_cfg(3'd3); clr_cnt();
        quad_fwd(2);
        chk("R6 x1 forward up", n_up, 2);
        chk("R6 x1 forward no down", n_dn, 0);
        clr_cnt();
        quad_rev(2);
        chk("R6 x1 reverse down", n_dn, 2);
        chk("R6 x1 reverse no up", n_up, 0);
    endtask

    task automatic t_x2();
        set_cfg(3'd4); clr_cnt();
        quad_fwd(1);
        chk("R7 x2 forward up", n_up, 2);
        chk("R7 x2 forward no down", n_dn, 0);
        clr_cnt();
        quad_rev(1);
        chk("R7 x2 reverse down", n_dn, 2);
        chk("R7 x2 reverse no up", n_up, 0);
    endtask

    task automatic t_x4();
        set_cfg(3'd5); clr_cnt();
        quad_fwd(2);
        chk("R8 x4 forward up", n_up, 8);
        chk("R8 x4 forward no down", n_dn, 0);
        clr_cnt();
        quad_rev(1);
        chk("R8 x4 reverse down", n_dn, 4);
        chk("R8 x4 reverse no up", n_up, 0);
        clr_cnt();
        apply(1, 1); apply(0, 0);
        chk("R9 x4 both inputs together cancel", n_up + n_dn, 0);
    endtask

    task automatic t_cfg_change();
        set_cfg(3'd2); clr_cnt();
        @(negedge clk) a_in = 1'b1;
        @(negedge clk);
        @(negedge clk) cfg_sel = 3'd0;
        repeat (5) @(negedge clk);
        chk("R10 edge at select change dropped", n_up + n_dn, 0);
        apply(0, 0); clr_cnt();
        apply(1, 0);
        chk("R10 later edge counts normally", n_up, 1);
        apply(0, 0); clr_cnt();
    endtask

    task automatic t_reserved();
        set_cfg(3'd6); clr_cnt();
        quad_fwd(1);
        apply(1, 0); apply(0, 0); apply(0, 1); apply(0, 0);
        chk("R11 select 6 quiet", n_up + n_dn, 0);
        set_cfg(3'd7); clr_cnt();
        quad_rev(1);
        chk("R11 select 7 quiet", n_up + n_dn, 0);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_ext_dir();
        t_int_dir();
        t_up_down();
        t_x1();
        t_x2();
        t_x4();
        t_cfg_change();
        t_reserved();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule